// File: doc/BRIEF.md
# Data Address Breakpoint Matcher

This block watches the data accesses of a processor pipeline and tells the debug logic, in the same cycle as the access is presented, whether the access touches a watched memory region. It keeps a parameterised number of breakpoint pairs, each made of an address word and a control word. The control word says whether the pair watches loads, stores or both, and carries a small mask field that turns the low-order address bits into don't-care bits, so a pair covers an aligned region of 1 to 64 bytes.

A hit is reported as a one-hot vector that names the pair that matched (the lowest index wins when several do), plus a single hit flag. The result is purely combinational from the access inputs, so the requester sees it before the access completes and must suppress the access itself. The access side has no ready signal: the matcher never applies back-pressure and every cycle with `acc_valid` high is evaluated on its own. The two words of each pair are loaded through a plain write port. A non-contiguous mask field is not used bitwise: it is truncated after its first zero bit, counting down from the top of the field.

Top module: `dbrk_matcher`

## Requirements
- R1: After reset every pair is disabled and no access produces a hit.
- R2: A pair matches stores only when control bit 31 (store watch) is set and loads only when control bit 30 (load watch) is set; with both bits clear the pair never matches.
- R3: Control bits 5:0 form the mask field; each bit position that is 0 below the highest run of ones makes that address bit a don't-care, so the pair covers the 2^k-byte aligned region containing its address. Control bits 29:6 have no effect on matching.
- R4: A mask field that is not of the form ones-then-zeros is truncated after its first zero bit from bit 5 downward: k equals 6 minus the number of consecutive ones starting at bit 5 (0x2F gives k=5, 0x15 gives k=6).
- R5: An access hits a pair when (access address AND mask) equals (breakpoint address AND mask); the hit outputs are valid in the same cycle as the access.
- R6: `acc_size` is log2 of the access width in bytes (0 to 3 for 1 to 8 bytes); a wider access hits when any of its bytes lies in the region, and address bits below the access width are ignored.
- R7: `brk_vec` is one-hot and names the lowest-index pair that matches; `brk_hit` is high whenever any pair matches.
- R8: A register write (`cfg_sel` 0 = address word, 1 = control word, `cfg_idx` = pair) takes effect for accesses from the cycle after the write edge; an access in the write cycle sees the old setting.
- R9: An address write to a disabled pair does not arm it, but the stored value is used once the pair is enabled; a control write that changes only bits 29:6 leaves matching unchanged.
- R10: With `acc_valid` low no hit is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 1 | Pair index of the write |
| cfg_sel | input | 1 | 0 writes the address word, 1 the control word |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | log2 of the access width in bytes |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| brk_vec | output | 2 | One-hot index of the matching pair |
| brk_hit | output | 1 | Any pair matched; the access must be suppressed |

## Verification
Hit outputs are due in the very cycle an access is presented, with no register between the access inputs and `brk_vec`/`brk_hit`, so each check drives the access on a falling edge and samples 2 ns later, before the next rising edge. Register writes are committed on the rising edge after the strobe is driven, so a write is only expected to affect accesses presented from the following falling edge; one scenario samples an access inside the write cycle to confirm the old setting still applies. Expected vectors come from a bench model of the stored words, the truncated mask width and the access width.

// File: rtl/dbrk_pkg.sv
`timescale 1ns/1ps
package dbrk_pkg;
  // control word field positions (decoded by the pair logic)
  localparam int CTRL_ST_BIT = 31;
  localparam int CTRL_LD_BIT = 30;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbrk_pair.sv
`timescale 1ns/1ps
module dbrk_pair
  import dbrk_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MASK_W = 6,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              acc_valid_i,
  input  logic [DW-1:0]     acc_addr_i,
  input  logic [SIZE_W-1:0] acc_size_i,
  input  logic              acc_store_i,
  output logic              hit_o
);
  localparam int KW = $clog2(MASK_W + 1);
  localparam logic [DW-1:0] REL_BITS =
    {2'b11, {(DW-2-MASK_W){1'b0}}, {MASK_W{1'b1}}};

  logic [DW-1:0] addr_q, ctrl_q;
  logic [DW-1:0] arm_base;
  logic [KW-1:0] arm_k;
  logic          arm_ld, arm_st;

  logic [KW-1:0] new_k;
  logic          ctrl_diff;
  logic          enabled_now;

  // width of the don't-care range after truncation at the first zero
  always_comb begin
    int  ones;
    logic run;
    ones = 0;
    run  = 1'b1;
    for (int b = MASK_W - 1; b >= 0; b--) begin
      if (run && wr_data_i[b]) ones = ones + 1;
      else                     run  = 1'b0;
    end
    new_k = KW'(MASK_W - ones);
  end

  assign ctrl_diff   = |((ctrl_q ^ wr_data_i) & REL_BITS);
  assign enabled_now = ctrl_q[CTRL_ST_BIT] | ctrl_q[CTRL_LD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      ctrl_q   <= '0;
      arm_base <= '0;
      arm_k    <= '0;
      arm_ld   <= 1'b0;
      arm_st   <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CTRL) begin
        ctrl_q <= wr_data_i;
        if (ctrl_diff) begin
          arm_base <= addr_q;
          arm_k    <= new_k;
          arm_st   <= wr_data_i[CTRL_ST_BIT];
          arm_ld   <= wr_data_i[CTRL_LD_BIT];
        end
      end else begin
        addr_q <= wr_data_i;
        if (enabled_now && (wr_data_i != addr_q)) arm_base <= wr_data_i;
      end
    end
  end

  // comparator: ignore bits below the larger of region and access width
  logic [DW-1:0] care;
  logic          dir_ok, match;

  always_comb begin
    int dc;
    dc = (int'(arm_k) > int'(acc_size_i)) ? int'(arm_k) : int'(acc_size_i);
    for (int b = 0; b < DW; b++) care[b] = (b >= dc);
  end

  assign dir_ok = acc_store_i ? arm_st : arm_ld;
  assign match  = ((acc_addr_i ^ arm_base) & care) == '0;
  assign hit_o  = acc_valid_i & dir_ok & match;

  // R9: an address write to a disabled pair leaves the armed base alone
  p_disabled_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_ADDR && !enabled_now) |=> $stable(arm_base));

  // R9: a control write touching only the unused bits keeps the armed setting
  p_ctrl_unused_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_CTRL &&
     ((ctrl_q ^ wr_data_i) & REL_BITS) == '0)
    |=> ($stable(arm_k) && $stable(arm_ld) && $stable(arm_st)));

  // R4: the truncated don't-care width never exceeds the field
  p_k_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(arm_k) <= MASK_W);

  // R1: leaving reset, the pair is disarmed
  p_reset_disarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!arm_ld && !arm_st));
endmodule

// File: rtl/dbrk_pick.sv
`timescale 1ns/1ps
module dbrk_pick #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // isolate the lowest set bit
  assign gnt_o = req_i & (~req_i + N'(1));

  // R7: at most one pair is reported
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R7: a report exists exactly when some pair matched
  p_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) == (|gnt_o));
endmodule

// File: rtl/dbrk_matcher.sv
`timescale 1ns/1ps
module dbrk_matcher
  import dbrk_pkg::*;
#(
  parameter int NPAIR  = 2,
  parameter int DW     = 32,
  parameter int MASK_W = 6,
  parameter int SIZE_W = 2,
  localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              acc_valid,
  input  logic [DW-1:0]     acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_store,
  output logic [NPAIR-1:0]  brk_vec,
  output logic              brk_hit
);
  logic [NPAIR-1:0] raw_hit;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic sel_this;
    assign sel_this = cfg_we && (cfg_idx == IDX_W'(i));

    dbrk_pair #(
      .DW     (DW),
      .MASK_W (MASK_W),
      .SIZE_W (SIZE_W)
    ) u_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (sel_this),
      .wr_sel_i    (cfg_sel),
      .wr_data_i   (cfg_wdata),
      .acc_valid_i (acc_valid),
      .acc_addr_i  (acc_addr),
      .acc_size_i  (acc_size),
      .acc_store_i (acc_store),
      .hit_o       (raw_hit[i])
    );
  end

  dbrk_pick #(.N(NPAIR)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (raw_hit),
    .gnt_o (brk_vec)
  );

  assign brk_hit = |brk_vec;

  // R10: no access, no hit
  p_valid_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !brk_hit);
endmodule

// File: tb/dbrk_matcher_tb.sv
`timescale 1ns/1ps
module dbrk_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_idx = '0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_store = 1'b0;
  logic [1:0]  brk_vec;
  logic        brk_hit;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] m_addr [2];
  logic [31:0] m_ctrl [2];

  always #10 clk = ~clk;

  dbrk_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_store(acc_store),
    .brk_vec(brk_vec), .brk_hit(brk_hit)
  );

  // bench model built from the requirements
  function automatic logic [1:0] model(input logic v, input logic [31:0] a,
                                       input int sz, input logic st);
    logic [1:0] h;
    h = '0;
    for (int i = 0; i < 2; i++) begin
      int ones, k, dc;
      logic en;
      ones = 0;
      while (ones < 6 && m_ctrl[i][5-ones]) ones++;
      k  = 6 - ones;
      dc = (k > sz) ? k : sz;
      en = st ? m_ctrl[i][31] : m_ctrl[i][30];
      h[i] = v && en && ((a >> dc) == (m_addr[i] >> dc));
    end
    if (h[0]) h[1] = 1'b0;
    return h;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 1'(idx); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) m_ctrl[idx] = d; else m_addr[idx] = d;
  endtask

  // drive an access, sample same cycle, compare both outputs
  task automatic probe(input string req, input logic v, input logic [31:0] a,
                       input int sz, input logic st);
    logic [1:0] e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = 2'(sz); acc_store = st;
    #2;
    e = model(v, a, sz, st);
    check(req, $sformatf("vec @%h sz%0d st%0d", a, sz, st), brk_vec, e);
    check(req, "hit flag", {1'b0, brk_hit}, {1'b0, |e});
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;  // R1
    probe("R1", 1, 32'h0, 0, 1);
    probe("R1", 1, 32'h0, 0, 0);
  endtask

  task automatic t_direction;  // R2, R5
    wr(0, 0, 32'h1000);
    wr(0, 1, 32'h8000_003f);
    probe("R2", 1, 32'h1000, 0, 1);
    check("R2", "store-only pair hits store", brk_vec, 2'b01);
    probe("R2", 1, 32'h1000, 0, 0);
    wr(0, 1, 32'h4000_003f);
    probe("R2", 1, 32'h1000, 0, 0);
    probe("R2", 1, 32'h1000, 0, 1);
    wr(0, 1, 32'h0000_003f);
    probe("R2", 1, 32'h1000, 0, 0);
    probe("R2", 1, 32'h1000, 0, 1);
    wr(0, 1, 32'h8000_003f);
    probe("R5", 1, 32'h1001, 0, 1);
  endtask

  task automatic t_mask;  // R3
    wr(0, 0, 32'h2001);
    wr(0, 1, 32'h8000_ff3c);
    probe("R3", 1, 32'h2003, 0, 1);
    probe("R3", 1, 32'h2000, 0, 1);
    probe("R3", 1, 32'h2004, 0, 1);
    probe("R3", 1, 32'h1fff, 0, 1);
  endtask

  task automatic t_trunc;  // R4
    wr(0, 0, 32'h2000);
    wr(0, 1, 32'h8000_002f);
    probe("R4", 1, 32'h201f, 0, 1);
    probe("R4", 1, 32'h2020, 0, 1);
    wr(0, 1, 32'h8000_0015);
    probe("R4", 1, 32'h203f, 0, 1);
    check("R4", "0x15 covers 64 bytes", brk_vec, 2'b01);
    probe("R4", 1, 32'h2040, 0, 1);
  endtask

  task automatic t_wide;  // R6
    wr(0, 0, 32'h3002);
    wr(0, 1, 32'h4000_003f);
    probe("R6", 1, 32'h3000, 2, 0);
    probe("R6", 1, 32'h3000, 1, 0);
    probe("R6", 1, 32'h3002, 1, 0);
    probe("R6", 1, 32'h3000, 3, 0);
    probe("R6", 1, 32'h3003, 0, 0);
  endtask

  task automatic t_priority;  // R7
    wr(0, 0, 32'h7000);
    wr(0, 1, 32'hc000_003f);
    wr(1, 0, 32'h7000);
    wr(1, 1, 32'hc000_003f);
    probe("R7", 1, 32'h7000, 0, 1);
    check("R7", "lowest index wins", brk_vec, 2'b01);
    wr(0, 1, 32'h0);
    probe("R7", 1, 32'h7000, 0, 0);
    check("R7", "only pair 1", brk_vec, 2'b10);
  endtask

  task automatic t_arm;  // R9
    wr(1, 1, 32'h0);
    wr(1, 0, 32'h5000);
    probe("R9", 1, 32'h5000, 0, 1);
    wr(1, 1, 32'h8000_003f);
    probe("R9", 1, 32'h5000, 0, 1);
    check("R9", "stored address used after enable", brk_vec, 2'b10);
    wr(1, 1, 32'h8fff_ffff);
    probe("R9", 1, 32'h5000, 0, 1);
    probe("R9", 1, 32'h5001, 0, 1);
  endtask

  task automatic t_valid;  // R10
    probe("R10", 0, 32'h5000, 0, 1);
  endtask

  task automatic t_timing;  // R8
    wr(0, 0, 32'h1000);
    wr(0, 1, 32'h8000_003f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 1'b0; cfg_sel = 1'b0; cfg_wdata = 32'h6000;
    acc_valid = 1'b1; acc_addr = 32'h6000; acc_size = 2'd0; acc_store = 1'b1;
    #2;
    check("R8", "write cycle sees old address", brk_vec, 2'b00);
    @(negedge clk);
    cfg_we = 1'b0;
    m_addr[0] = 32'h6000;
    #2;
    check("R8", "next cycle sees new address", brk_vec, 2'b01);
    acc_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_addr[i] = '0; m_ctrl[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_mask();
    t_trunc();
    t_wide();
    t_priority();
    t_arm();
    t_valid();
    t_timing();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule